// File: doc/BRIEF.md
# Exception Entry State Capture Unit

This block decides what a processor core saves when it takes an exception. On a single-cycle request strobe the core gives the exception class, the trap cause, the address of the current instruction, the address of the next instruction, the live status word and the trace flag. The block captures them and presents a two-word frame for the interrupt stack: the shaped status word first, then the program counter. Each word uses a valid/ready handshake. The frame depends on the class. A completed instruction saves the next address. A suspended instruction saves its own address so it can run again. An undefined-instruction trap, or a string instruction stopped partway through, also clears the pending-trace bit in the saved status copy. A reset terminates the instruction and pushes no frame.

A small return path sits beside the push side. When the core pops a frame and strobes it in, the block hands back the status word and program counter to restore, one cycle later. Execution then resumes at the saved address. For a partly done string operation, that address lets the operation continue from where it stopped. Stack memory access, vector fetch and instruction execution belong to the surrounding core.

Top module: `exc_frame_former`

## Requirements
- R1: After reset, busy and push_valid are low and req_ready is high.
- R2: For class code 0 (completed), the second pushed word holds next_pc.
- R3: For class code 0, status bit PBIT (default 10) of the first pushed word equals trace_flag, and all other status bits equal live_psr.
- R4: For class code 1 (suspended), the second pushed word holds cur_pc.
- R5: For class code 1 with cause equal to UND_CAUSE (default 3), status bit PBIT of the first word is 0, and all other bits equal live_psr.
- R6: For class code 1 with any other cause, the first word equals live_psr unchanged.
- R7: For class code 2 (partially completed), the second word holds cur_pc and status bit PBIT of the first word is 0, with all other bits unchanged.
- R8: For class code 3 (reset), a request is accepted, no word is pushed and busy stays low.
- R9: The status word is pushed first with push_sel=0, then the PC with push_sel=1. push_data and push_sel hold steady while push_valid is high and push_ready is low.
- R10: busy rises the cycle after an accepted frame request and falls the cycle after the PC word is accepted. While busy, req_ready is low and a request strobe is ignored.
- R11: One cycle after ret_go, restore_valid is high for one cycle, with restore_pc and restore_psr equal to the ret_pc and ret_psr sampled with ret_go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Single-cycle exception request strobe |
| req_ready | output | 1 | High when a request can be taken |
| req_class | input | 2 | 0 completed, 1 suspended, 2 partial, 3 reset |
| req_cause | input | CW | Trap cause code |
| cur_pc | input | AW | Address of the current instruction |
| next_pc | input | AW | Address of the next instruction |
| live_psr | input | SW | Live status word |
| trace_flag | input | 1 | Trace enable flag |
| busy | output | 1 | Frame push in progress |
| push_valid | output | 1 | Frame word valid |
| push_ready | input | 1 | Stack side accepts the word |
| push_sel | output | 1 | 0 status word, 1 program counter |
| push_data | output | DW | Frame word, zero-extended |
| ret_go | input | 1 | Popped frame present |
| ret_pc | input | AW | Popped program counter |
| ret_psr | input | SW | Popped status word |
| restore_valid | output | 1 | Restore values valid |
| restore_pc | output | AW | PC to resume at |
| restore_psr | output | SW | Status word to restore |

## Verification
Requests of every class are sent with the trace flag both set and clear, and with the pending bit of the live status both set and clear. This separates a P bit taken from the trace flag, a P bit cleared, and a P bit passed through. Suspended requests use both the undefined-instruction cause and other causes, to show that only that one cause clears the bit. Different current and next addresses show which one each class saves. The stack side's ready toggles in a pseudo-random pattern, so word order and hold behaviour are seen under back-pressure. A strobe raised while busy, and a reset-class request, must add no words to the expected stream.

// File: rtl/exc_cap_pkg.sv
package exc_cap_pkg;
   typedef enum logic [1:0] {
      CLS_DONE = 2'd0,
      CLS_SUSP = 2'd1,
      CLS_PART = 2'd2,
      CLS_TERM = 2'd3
   } exc_cls_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_PSR  = 2'd1,
      SQ_PC   = 2'd2
   } push_st_t;
endpackage

// File: rtl/exc_frame_shape.sv
module exc_frame_shape
   import exc_cap_pkg::*;
#(
   parameter int AW        = 32,
   parameter int SW        = 16,
   parameter int CW        = 4,
   parameter int PBIT      = 10,
   parameter int UND_CAUSE = 3
) (
   input  exc_cls_t        cls,
   input  logic [CW-1:0]   cause,
   input  logic [AW-1:0]   cur_pc,
   input  logic [AW-1:0]   next_pc,
   input  logic [SW-1:0]   psr_in,
   input  logic            trace,
   output logic [AW-1:0]   save_pc,
   output logic [SW-1:0]   save_psr
);
   localparam logic [CW-1:0] UND_CODE = CW'(UND_CAUSE);

   logic p_bit;

   always_comb begin
      save_pc = cur_pc;
      p_bit   = psr_in[PBIT];
      unique case (cls)
         CLS_DONE: begin
            save_pc = next_pc;
            p_bit   = trace;
         end
         CLS_SUSP: begin
            if (cause == UND_CODE) p_bit = 1'b0;
         end
         CLS_PART: p_bit = 1'b0;
         default:  p_bit = psr_in[PBIT];
      endcase
      save_psr       = psr_in;
      save_psr[PBIT] = p_bit;
   end
endmodule

// File: rtl/exc_push_seq.sv
module exc_push_seq
   import exc_cap_pkg::*;
#(
   parameter int AW = 32,
   parameter int SW = 16,
   parameter int CW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  exc_cls_t        req_class,
   input  logic [CW-1:0]   req_cause,
   input  logic [AW-1:0]   cur_pc,
   input  logic [AW-1:0]   next_pc,
   input  logic [SW-1:0]   live_psr,
   input  logic            trace_flag,
   input  logic            push_ready,
   output logic            req_ready,
   output logic            busy,
   output logic            push_valid,
   output logic            push_sel,
   output exc_cls_t        cap_class,
   output logic [CW-1:0]   cap_cause,
   output logic [AW-1:0]   cap_cur,
   output logic [AW-1:0]   cap_next,
   output logic [SW-1:0]   cap_psr,
   output logic            cap_trace
);
   push_st_t st_q, st_d;
   logic     take;

   assign take      = req_valid && (st_q == SQ_IDLE);
   assign req_ready = (st_q == SQ_IDLE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQ_IDLE: if (take && req_class != CLS_TERM) st_d = SQ_PSR;
         SQ_PSR:  if (push_ready) st_d = SQ_PC;
         SQ_PC:   if (push_ready) st_d = SQ_IDLE;
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         cap_class <= CLS_DONE;
         cap_cause <= '0;
         cap_cur   <= '0;
         cap_next  <= '0;
         cap_psr   <= '0;
         cap_trace <= 1'b0;
      end else begin
         st_q <= st_d;
         if (take) begin
            cap_class <= req_class;
            cap_cause <= req_cause;
            cap_cur   <= cur_pc;
            cap_next  <= next_pc;
            cap_psr   <= live_psr;
            cap_trace <= trace_flag;
         end
      end
   end

   assign busy       = (st_q != SQ_IDLE);
   assign push_valid = busy;
   assign push_sel   = (st_q == SQ_PC);

   p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && push_ready && !push_sel |=> push_valid && push_sel);

   p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && push_ready && push_sel |=> !busy);

   p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_class != CLS_TERM |=> busy && !push_sel);

   p_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_class == CLS_TERM |=> !busy);

   p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !(push_valid && push_ready) |=> $stable(cap_cur) && $stable(cap_class));
endmodule

// File: rtl/exc_return_path.sv
module exc_return_path #(
   parameter int AW      = 32,
   parameter int SW      = 16,
   parameter bit REG_RET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ret_go,
   input  logic [AW-1:0] ret_pc,
   input  logic [SW-1:0] ret_psr,
   output logic          restore_valid,
   output logic [AW-1:0] restore_pc,
   output logic [SW-1:0] restore_psr
);
   generate
      if (REG_RET) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               restore_valid <= 1'b0;
               restore_pc    <= '0;
               restore_psr   <= '0;
            end else begin
               restore_valid <= ret_go;
               if (ret_go) begin
                  restore_pc  <= ret_pc;
                  restore_psr <= ret_psr;
               end
            end
         end

         p_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ret_go |=> restore_valid && restore_pc == $past(ret_pc)
                       && restore_psr == $past(ret_psr));
      end else begin : g_pass
         assign restore_valid = ret_go;
         assign restore_pc    = ret_pc;
         assign restore_psr   = ret_psr;
      end
   endgenerate
endmodule

// File: rtl/exc_frame_former.sv
module exc_frame_former
   import exc_cap_pkg::*;
#(
   parameter int AW        = 32,
   parameter int SW        = 16,
   parameter int CW        = 4,
   parameter int PBIT      = 10,
   parameter int UND_CAUSE = 3,
   parameter bit REG_RET   = 1'b1,
   localparam int DW       = (AW > SW) ? AW : SW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_class,
   input  logic [CW-1:0] req_cause,
   input  logic [AW-1:0] cur_pc,
   input  logic [AW-1:0] next_pc,
   input  logic [SW-1:0] live_psr,
   input  logic          trace_flag,
   output logic          busy,
   output logic          push_valid,
   input  logic          push_ready,
   output logic          push_sel,
   output logic [DW-1:0] push_data,
   input  logic          ret_go,
   input  logic [AW-1:0] ret_pc,
   input  logic [SW-1:0] ret_psr,
   output logic          restore_valid,
   output logic [AW-1:0] restore_pc,
   output logic [SW-1:0] restore_psr
);
   generate
      if (PBIT < 0 || PBIT >= SW) begin : g_bad_pbit
         $error("PBIT must lie inside the status word");
      end
      if (CW < 1 || (UND_CAUSE >> CW) != 0) begin : g_bad_cause
         $error("UND_CAUSE must fit in CW bits");
      end
   endgenerate

   exc_cls_t        cap_class;
   logic [CW-1:0]   cap_cause;
   logic [AW-1:0]   cap_cur, cap_next, save_pc;
   logic [SW-1:0]   cap_psr, save_psr;
   logic            cap_trace;
   logic [DW-1:0]   pc_word, psr_word;

   exc_push_seq #(.AW(AW), .SW(SW), .CW(CW)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_class  (exc_cls_t'(req_class)),
      .req_cause  (req_cause),
      .cur_pc     (cur_pc),
      .next_pc    (next_pc),
      .live_psr   (live_psr),
      .trace_flag (trace_flag),
      .push_ready (push_ready),
      .req_ready  (req_ready),
      .busy       (busy),
      .push_valid (push_valid),
      .push_sel   (push_sel),
      .cap_class  (cap_class),
      .cap_cause  (cap_cause),
      .cap_cur    (cap_cur),
      .cap_next   (cap_next),
      .cap_psr    (cap_psr),
      .cap_trace  (cap_trace)
   );

   exc_frame_shape #(.AW(AW), .SW(SW), .CW(CW), .PBIT(PBIT),
                     .UND_CAUSE(UND_CAUSE)) shape_i (
      .cls      (cap_class),
      .cause    (cap_cause),
      .cur_pc   (cap_cur),
      .next_pc  (cap_next),
      .psr_in   (cap_psr),
      .trace    (cap_trace),
      .save_pc  (save_pc),
      .save_psr (save_psr)
   );

   generate
      if (AW == DW) begin : g_pc_full
         assign pc_word = save_pc;
      end else begin : g_pc_pad
         assign pc_word = {{(DW-AW){1'b0}}, save_pc};
      end
      if (SW == DW) begin : g_psr_full
         assign psr_word = save_psr;
      end else begin : g_psr_pad
         assign psr_word = {{(DW-SW){1'b0}}, save_psr};
      end
   endgenerate

   assign push_data = push_sel ? pc_word : psr_word;

   exc_return_path #(.AW(AW), .SW(SW), .REG_RET(REG_RET)) ret_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .ret_go        (ret_go),
      .ret_pc        (ret_pc),
      .ret_psr       (ret_psr),
      .restore_valid (restore_valid),
      .restore_pc    (restore_pc),
      .restore_psr   (restore_psr)
   );

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && !push_ready |=> push_valid && $stable(push_data) && $stable(push_sel));

   p_pclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && !push_sel && cap_class == CLS_PART |-> push_data[PBIT] == 1'b0);

   p_donepc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && push_sel && cap_class == CLS_DONE |-> push_data[AW-1:0] == cap_next);
endmodule

// File: tb/exc_frame_former_tb.sv
module exc_frame_former_tb_top;
   localparam int AW = 32, SW = 16, CW = 4, PBIT = 10, UNDC = 3;
   localparam int DW = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, trace_flag = 0, push_ready = 0, ret_go = 0;
   logic [1:0] req_class = 0;
   logic [CW-1:0] req_cause = 0;
   logic [AW-1:0] cur_pc = 0, next_pc = 0, ret_pc = 0;
   logic [SW-1:0] live_psr = 0, ret_psr = 0;
   logic req_ready, busy, push_valid, push_sel, restore_valid;
   logic [DW-1:0] push_data;
   logic [AW-1:0] restore_pc;
   logic [SW-1:0] restore_psr;

   int total = 0, bad = 0, cyc = 0;
   logic [DW:0] exp_q[$];
   string tag_q[$];
   logic [7:0] lfsr = 8'hA5;
   bit always_rdy = 1'b1;
   bit hold_seen = 0;
   logic [DW:0] hold_val;

   always #5 clk = ~clk;

   exc_frame_former dut_i (.*);

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // monitor: drives ready, then checks the handshake of the coming edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         chk(0, "watchdog", 0, 1);
         finish_up();
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      push_ready = always_rdy ? 1'b1 : lfsr[0];
      #1;
      if (rst_n && push_valid) begin
         if (hold_seen)
            chk({push_sel, push_data} == hold_val, "R9 hold", {push_sel, push_data}, hold_val);
         hold_seen = !push_ready;
         hold_val  = {push_sel, push_data};
         if (push_ready) begin
            if (exp_q.size() == 0) begin
               chk(0, "R10 unexpected word", {push_sel, push_data}, 0);
            end else begin
               logic [DW:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk({push_sel, push_data} == e, t, {push_sel, push_data}, e);
            end
         end
      end else begin
         hold_seen = 0;
      end
   end

   function automatic logic [SW-1:0] shape_psr(input logic [1:0] c, input logic [CW-1:0] k,
                                              input logic [SW-1:0] p, input logic t);
      logic [SW-1:0] r;
      r = p;
      if (c == 2'd0) r[PBIT] = t;
      else if (c == 2'd2) r[PBIT] = 1'b0;
      else if (c == 2'd1 && k == CW'(UNDC)) r[PBIT] = 1'b0;
      return r;
   endfunction

   task automatic send(input logic [1:0] c, input logic [CW-1:0] k, input logic [AW-1:0] cp,
                       input logic [AW-1:0] np, input logic [SW-1:0] p, input logic t,
                       input string tp, input string tc);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_class = c; req_cause = k; cur_pc = cp; next_pc = np;
      live_psr = p; trace_flag = t; req_valid = 1'b1;
      if (c != 2'd3) begin
         exp_q.push_back({1'b0, 16'h0, shape_psr(c, k, p, t)});
         tag_q.push_back(tp);
         exp_q.push_back({1'b1, (c == 2'd0) ? np : cp});
         tag_q.push_back(tc);
      end
      @(negedge clk);
      req_valid = 1'b0;
      #2;
      if (c != 2'd3) begin
         chk(busy === 1'b1, "R10 busy after accept", busy, 1);
         chk(req_ready === 1'b0, "R10 ready low while busy", req_ready, 0);
      end else begin
         chk(busy === 1'b0 && push_valid === 1'b0, "R8 no push on reset class", busy, 0);
      end
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || busy) @(negedge clk);
      @(negedge clk); #2;
      chk(busy === 1'b0 && req_ready === 1'b1, "R10 idle after frame", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      chk(busy === 1'b0 && push_valid === 1'b0 && req_ready === 1'b1, "R1 reset state",
          {busy, push_valid, req_ready}, 3'b001);
      rst_n = 1'b1;

      // completed class with trace on/off and P live set/clear
      send(2'd0, 4'h0, 32'h1000, 32'h1004, 16'h0400, 1'b0, "R3 done P=trace 0", "R2 done pc");
      send(2'd0, 4'h0, 32'h2000, 32'h2003, 16'h0000, 1'b1, "R3 done P=trace 1", "R2 done pc");
      // suspended: undefined trap vs other
      send(2'd1, 4'h3, 32'h3000, 32'h3006, 16'hFFFF, 1'b1, "R5 und P clear", "R4 susp pc");
      send(2'd1, 4'h5, 32'h4000, 32'h4002, 16'h0C01, 1'b0, "R6 other P kept", "R4 susp pc");
      send(2'd1, 4'h7, 32'h4100, 32'h4102, 16'h0000, 1'b1, "R6 other P kept 0", "R4 susp pc");
      // partial
      send(2'd2, 4'h0, 32'h5000, 32'h5002, 16'h8421, 1'b1, "R7 part P clear", "R7 part pc");
      send(2'd2, 4'h9, 32'h5100, 32'h5102, 16'h0400, 1'b0, "R7 part P clear", "R7 part pc");
      drain();
      // reset class
      send(2'd3, 4'h0, 32'h6000, 32'h6004, 16'h0400, 1'b1, "", "");
      drain();

      // back-pressure on the stack side
      always_rdy = 1'b0;
      send(2'd0, 4'h2, 32'h7000, 32'h7008, 16'h1234, 1'b1, "R9 order psr", "R9 order pc");
      // strobe while busy must be ignored
      @(negedge clk);
      if (busy) begin
         req_class = 2'd1; req_cause = 4'h3; cur_pc = 32'hDEAD; live_psr = 16'hFFFF;
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
      end
      send(2'd1, 4'h3, 32'h8000, 32'h8002, 16'h0555, 1'b0, "R5 und under bp", "R4 pc under bp");
      send(2'd2, 4'h1, 32'h9000, 32'h9004, 16'hFFFF, 1'b1, "R7 psr under bp", "R7 pc under bp");
      drain();
      always_rdy = 1'b1;

      // return path
      @(negedge clk);
      ret_pc = 32'hABCD0010; ret_psr = 16'h0F0F; ret_go = 1'b1;
      @(negedge clk);
      ret_go = 1'b0; ret_pc = 32'h0; ret_psr = 16'h0;
      #2;
      chk(restore_valid === 1'b1, "R11 restore valid", restore_valid, 1);
      chk(restore_pc === 32'hABCD0010, "R11 restore pc", restore_pc, 32'hABCD0010);
      chk(restore_psr === 16'h0F0F, "R11 restore psr", restore_psr, 16'h0F0F);
      @(negedge clk); #2;
      chk(restore_valid === 1'b0, "R11 one cycle", restore_valid, 0);

      chk(exp_q.size() == 0, "R10 leftover words", exp_q.size(), 0);
      finish_up();
   end
endmodule